// File: doc/BRIEF.md
# Keyed Codeword Bit Scrambler and Unscrambler

This block protects a 38-bit error-coded word (32 data bits plus 6 check bits) while it crosses a shared interconnect. A send stage reorders the bits of each word according to one of eight patterns picked by a 3-bit key. A receive stage restores the original order before the word reaches syndrome calculation. A wire that is stuck or tampered with on the link therefore lands on a different logical bit every time the key changes. This spreads a persistent fault across positions that the downstream code can tell apart.

The send stage takes the key along with each accepted word and registers it beside the scrambled word. The receive stage unscrambles the word on the link with that registered key. The two stages therefore always agree, even when the key changes between back-to-back words. Each stage is a single register stage with valid signalling. The link itself leaves the block, so the interconnect sits between `link_word_o` and `link_word_i`.

Top module: `keyed_perm_link`

## Requirements
- R1: Key 0 is the identity. One cycle after a word is accepted with key 0, `link_word_o` equals that word.
- R2: For a nonzero key k, bit b of the accepted word appears on link bit (b*(2k+1) + 2k-1) mod 38, one cycle after acceptance.
- R3: Under every nonzero key no bit stays at its own position, and the eight keys give eight distinct orderings.
- R4: `rx_word_o` bit b equals `link_word_i` bit (b*(2k+1) + 2k-1) mod 38, or bit b for k=0, where k is the key registered with the most recent accepted word. With the link connected straight through, the original word is recovered for every key.
- R5: The key is sampled only together with an accepted word. When two words are sent back to back with different keys, each word is unscrambled with its own key.
- R6: When `tx_valid_i` is low, `link_valid_o` is low on the next cycle and `link_word_o` holds its value, whatever `tx_word_i` and `key_i` do.
- R7: `rx_valid_o` follows `link_valid_i` one cycle later. While `link_valid_i` is low, `rx_word_o` holds.
- R8: While `rst_ni` is low, both valid outputs and both word outputs are zero, and the registered key is 0.
- R9: A link wire stuck at 1 on word 0 corrupts exactly one logical bit of `rx_word_o`, and that position differs for each of the eight keys.
- R10: The total latency from `tx_word_i` to `rx_word_o` is two cycles when the link is connected directly. Each stage adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 3 | Pattern select, sampled with each accepted word |
| tx_valid_i | input | 1 | Send word valid |
| tx_word_i | input | 38 | Coded word to send |
| link_valid_o | output | 1 | Valid on the link |
| link_word_o | output | 38 | Scrambled word driven onto the link |
| link_valid_i | input | 1 | Valid arriving from the link |
| link_word_i | input | 38 | Scrambled word arriving from the link |
| rx_valid_o | output | 1 | Restored word valid |
| rx_word_o | output | 38 | Restored coded word |

## Verification
The bench drives words with every key and compares the link word against the lane formula. A design with a wrong pattern table, or one that uses the forward map on the receive side, returns corrupted words. Back-to-back words with different keys catch a receive stage that uses the live key rather than the one sent with the word; such a design would garble the first word. A stuck-at-1 link wire driven under all eight keys must move through eight different logical positions and must never sit at its own index under a nonzero key. A collapsed or repeated pattern would show up as two keys hitting the same bit. Idle cycles with changing inputs show whether a register loads without a valid.

// File: rtl/keyed_perm_pkg.sv
package keyed_perm_pkg;
  parameter int unsigned CW         = 38;
  parameter int unsigned KEY_W      = 3;
  localparam int unsigned NUM_KEYS  = 1 << KEY_W;

  // link lane carrying codeword bit pos under key; multiplier 2k+1 must be coprime with CW
  function automatic int unsigned lane_of(int unsigned key, int unsigned pos);
    if (key == 0) return pos;
    return (pos * (2 * key + 1) + 2 * key - 1) % CW;
  endfunction
endpackage

// File: rtl/perm_net.sv
module perm_net
  import keyed_perm_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [CW-1:0]    word_i,
  output logic [CW-1:0]    word_o
);
  logic [CW-1:0] cand [NUM_KEYS];

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    for (genvar b = 0; b < CW; b++) begin : g_bit
      localparam int unsigned LANE = lane_of(k, b);
      if (INVERSE) begin : g_inv
        assign cand[k][b] = word_i[LANE];
      end else begin : g_fwd
        assign cand[k][LANE] = word_i[b];
      end
    end
  end

  assign word_o = cand[key_i];
endmodule

// File: rtl/perm_tx_stage.sv
module perm_tx_stage
  import keyed_perm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [CW-1:0]    word_i,
  output logic             valid_o,
  output logic [KEY_W-1:0] key_o,
  output logic [CW-1:0]    word_o
);
  logic [CW-1:0] mixed;

  perm_net #(.INVERSE(1'b0)) u_fwd (
    .key_i (key_i),
    .word_i(word_i),
    .word_o(mixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      key_o   <= '0;
      word_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        key_o  <= key_i;  // key travels with its word
        word_o <= mixed;
      end
    end
  end
endmodule

// File: rtl/perm_rx_stage.sv
module perm_rx_stage
  import keyed_perm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [CW-1:0]    word_i,
  output logic             valid_o,
  output logic [CW-1:0]    word_o
);
  logic [CW-1:0] restored;

  perm_net #(.INVERSE(1'b1)) u_inv (
    .key_i (key_i),
    .word_i(word_i),
    .word_o(restored)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) word_o <= restored;
    end
  end
endmodule

// File: rtl/keyed_perm_link.sv
module keyed_perm_link
  import keyed_perm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [KEY_W-1:0] key_i,
  input  logic             tx_valid_i,
  input  logic [CW-1:0]    tx_word_i,
  output logic             link_valid_o,
  output logic [CW-1:0]    link_word_o,
  input  logic             link_valid_i,
  input  logic [CW-1:0]    link_word_i,
  output logic             rx_valid_o,
  output logic [CW-1:0]    rx_word_o
);
  logic [KEY_W-1:0] flight_key;

  perm_tx_stage u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(tx_valid_i),
    .key_i  (key_i),
    .word_i (tx_word_i),
    .valid_o(link_valid_o),
    .key_o  (flight_key),
    .word_o (link_word_o)
  );

  perm_rx_stage u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(link_valid_i),
    .key_i  (flight_key),
    .word_i (link_word_i),
    .valid_o(rx_valid_o),
    .word_o (rx_word_o)
  );
endmodule

// File: rtl/keyed_perm_link_chk.sv
module keyed_perm_link_chk
  import keyed_perm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [KEY_W-1:0] key_i,
  input logic             tx_valid_i,
  input logic [CW-1:0]    tx_word_i,
  input logic             link_valid_o,
  input logic [CW-1:0]    link_word_o,
  input logic             link_valid_i,
  input logic [CW-1:0]    link_word_i,
  input logic             rx_valid_o,
  input logic [CW-1:0]    rx_word_o
);
  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (!link_valid_o && !rx_valid_o && link_word_o == '0 && rx_word_o == '0));

  assert_identity_key_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && key_i == '0) |=> link_word_o == $past(tx_word_i));

  assert_bijection_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> $countones(link_word_o) == $countones($past(tx_word_i)));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_i |=> (!link_valid_o && $stable(link_word_o)));

  assert_tx_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> link_valid_o);

  assert_rx_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_i |=> rx_valid_o);

  assert_rx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_valid_i |=> (!rx_valid_o && $stable(rx_word_o)));

  // straight-through link: word comes back unchanged two cycles later
  assert_round_trip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_valid_i) && link_valid_i && link_word_i == link_word_o)
      |=> rx_word_o == $past(tx_word_i, 2));
endmodule

bind keyed_perm_link keyed_perm_link_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .key_i       (key_i),
  .tx_valid_i  (tx_valid_i),
  .tx_word_i   (tx_word_i),
  .link_valid_o(link_valid_o),
  .link_word_o (link_word_o),
  .link_valid_i(link_valid_i),
  .link_word_i (link_word_i),
  .rx_valid_o  (rx_valid_o),
  .rx_word_o   (rx_word_o)
);

// File: tb/keyed_perm_link_tb_top.sv
`timescale 1ns/1ps
module keyed_perm_link_tb_top;
  localparam int W = 38;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    key_i = '0;
  logic          tx_valid_i = 1'b0;
  logic [W-1:0]  tx_word_i = '0;
  logic          link_valid_o, rx_valid_o;
  logic [W-1:0]  link_word_o, rx_word_o, link_word_i;
  logic [W-1:0]  stuck_mask = '0;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  assign link_word_i = link_word_o | stuck_mask;

  keyed_perm_link dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_i       (key_i),
    .tx_valid_i  (tx_valid_i),
    .tx_word_i   (tx_word_i),
    .link_valid_o(link_valid_o),
    .link_word_o (link_word_o),
    .link_valid_i(link_valid_o),
    .link_word_i (link_word_i),
    .rx_valid_o  (rx_valid_o),
    .rx_word_o   (rx_word_o)
  );

  // lane formula taken from R2
  function automatic int m_lane(int k, int b);
    if (k == 0) return b;
    return (b * (2 * k + 1) + 2 * k - 1) % W;
  endfunction

  function automatic logic [W-1:0] m_fwd(int k, logic [W-1:0] w);
    logic [W-1:0] r = '0;
    for (int b = 0; b < W; b++) r[m_lane(k, b)] = w[b];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {key, word}
  localparam logic [W+2:0] VEC [12] = '{
    {3'd0, 38'h01_2345_6789},
    {3'd1, 38'h00_0000_0001},
    {3'd2, 38'h20_0000_0000},
    {3'd3, 38'h3F_FFFF_FFFF},
    {3'd4, 38'h15_5555_5555},
    {3'd5, 38'h2A_AAAA_AAAA},
    {3'd6, 38'h3C_0FF0_0F0F},
    {3'd7, 38'h00_0000_8000},
    {3'd7, 38'h12_3456_789A},
    {3'd1, 38'h3F_0000_00FF},
    {3'd3, 38'h00_FFFF_0000},
    {3'd5, 38'h08_4210_8421}
  };

  task automatic send(input int k, input logic [W-1:0] w);
    key_i = k[2:0];
    tx_word_i = w;
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held_link, held_rx;
    int pos_seen [8];

    repeat (2) @(negedge clk_i);
    // R8: reset state
    chk(!link_valid_o && !rx_valid_o, "R8 valids", {37'd0, link_valid_o | rx_valid_o}, '0);
    chk(link_word_o == '0 && rx_word_o == '0, "R8 words", link_word_o | rx_word_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: R1/R2 link image, R4/R10 round trip
    for (int i = 0; i < 12; i++) begin
      int k = int'(VEC[i][W+2:W]);
      logic [W-1:0] w = VEC[i][W-1:0];
      send(k, w);
      chk(link_valid_o, "R10 link valid", {37'd0, link_valid_o}, 38'd1);
      chk(link_word_o == m_fwd(k, w), k == 0 ? "R1 identity" : "R2 lane map",
          link_word_o, m_fwd(k, w));
      @(negedge clk_i);
      chk(rx_valid_o && rx_word_o == w, "R4 round trip", rx_word_o, w);
    end

    // R5: back-to-back words with different keys
    key_i = 3'd3; tx_word_i = 38'h2B_CDEF_0123; tx_valid_i = 1'b1;
    @(negedge clk_i);
    chk(link_word_o == m_fwd(3, 38'h2B_CDEF_0123), "R5 first link", link_word_o, m_fwd(3, 38'h2B_CDEF_0123));
    key_i = 3'd6; tx_word_i = 38'h05_5AA5_F00F;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    chk(rx_word_o == 38'h2B_CDEF_0123, "R5 first word own key", rx_word_o, 38'h2B_CDEF_0123);
    chk(link_word_o == m_fwd(6, 38'h05_5AA5_F00F), "R5 second link", link_word_o, m_fwd(6, 38'h05_5AA5_F00F));
    @(negedge clk_i);
    chk(rx_word_o == 38'h05_5AA5_F00F, "R5 second word own key", rx_word_o, 38'h05_5AA5_F00F);

    // R6/R7: idle with moving inputs
    held_link = link_word_o;
    held_rx = rx_word_o;
    key_i = 3'd2; tx_word_i = 38'h3F_FFFF_0000;
    @(negedge clk_i);
    key_i = 3'd5; tx_word_i = 38'h00_1111_2222;
    @(negedge clk_i);
    chk(!link_valid_o && link_word_o == held_link, "R6 idle hold", link_word_o, held_link);
    chk(!rx_valid_o && rx_word_o == held_rx, "R7 rx hold", rx_word_o, held_rx);

    // R9/R3: link wire 5 stuck at 1
    stuck_mask = 38'd1 << 5;
    for (int k = 0; k < 8; k++) begin
      int exp_b = -1;
      for (int b = 0; b < W; b++) if (m_lane(k, b) == 5) exp_b = b;
      send(k, '0);
      @(negedge clk_i);
      chk(rx_word_o == (38'd1 << exp_b), "R9 stuck wire position", rx_word_o, 38'd1 << exp_b);
      pos_seen[k] = exp_b;
      if (k != 0) chk(rx_word_o[5] == 1'b0, "R3 no fixed point", rx_word_o, 38'd1 << exp_b);
      for (int j = 0; j < k; j++)
        if (pos_seen[j] == exp_b) chk(1'b0, "R3 keys distinct", 38'(exp_b), 38'(pos_seen[j]));
    end
    stuck_mask = '0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule